// File: doc/BRIEF.md
# Virtual Interrupt Delivery Controller

This block keeps the pending and in-service state of a virtualized local interrupt controller with 256 vectors. It decides when one of those vectors may be handed to the guest. Requests come in from software posting and from a self-interrupt port, and each one sets a bit in a request bitmap. The highest pending vector at or above 16 is kept in a requesting-vector register. A separate in-service bitmap tracks the vectors being handled. The highest of those is kept in a servicing-vector register. A current-priority register holds the priority the guest now runs at.

Pending vectors are considered only when an evaluation event occurs: a guest entry, a task-priority write, an end-of-interrupt (EOI), a self-interrupt or a software post. At that point the priority class of the requesting vector (bits 7:4) is compared with the class of the current priority. A strictly higher class is offered on a valid/ready output. The handshake moves the vector from the request bitmap into the in-service bitmap. An EOI retires the servicing vector. If that vector's bit is set in the EOI exit bitmap, the EOI also raises a one-cycle exit event that carries the vector number.

Top module: `vintr_ctrl`

## Requirements
- R1: After reset, dlv_valid, eoi_exit_valid, req_vec, svc_vec and cur_prio are all 0, and the request, in-service, task-priority and EOI exit state is empty.
- R2: A vector is offered only in the cycle after an evaluation event, and only if win_exit_ctl is 0 in that cycle and req_vec[7:4] is strictly greater than cur_prio[7:4]. An equal class is never offered.
- R3: On an accepted handshake (dlv_valid and dlv_ready high at a clock edge), svc_vec becomes dlv_vec, cur_prio becomes dlv_vec with bits 3:0 cleared, the in-service bit of dlv_vec is set and its request bit is cleared.
- R4: req_vec is updated one clock after any change to the request bitmap. It holds the index of the highest set request bit at or above 16, or 0 when there is none.
- R5: Once a vector has been offered, no further vector is offered until a new evaluation event occurs. Clearing win_exit_ctl, or reloading req_vec, does not offer anything by itself.
- R6: The evaluation events are post_valid, self_ipi_valid, vm_entry, prio_wr and eoi_wr.
- R7: On eoi_wr, the in-service bit of svc_vec is cleared. svc_vec is then reloaded with the highest remaining in-service index, or 0. cur_prio is recomputed as in R9.
- R8: When eoi_wr is applied while svc_vec is 16 or above and the EOI exit bit of svc_vec is set, eoi_exit_valid is 1 for the next cycle only, and eoi_exit_vec carries that vector. Otherwise no exit event occurs.
- R9: On prio_wr, the task priority takes prio_val. cur_prio becomes the task priority if its bits 7:4 are at least svc_vec[7:4]; otherwise it becomes svc_vec with bits 3:0 cleared.
- R10: Vectors 0 to 15 are never offered and never appear in req_vec, even when their request bits are set.
- R11: While dlv_valid is 1 and dlv_ready is 0, dlv_valid stays 1 and dlv_vec stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Software post of a request; evaluation event |
| post_vec | input | 8 | Vector to post |
| self_ipi_valid | input | 1 | Self-interrupt request; evaluation event |
| self_ipi_vec | input | 8 | Self-interrupt vector |
| vm_entry | input | 1 | Guest entry; evaluation event |
| prio_wr | input | 1 | Task-priority write; evaluation event |
| prio_val | input | 8 | New task priority |
| eoi_wr | input | 1 | End-of-interrupt write; evaluation event |
| exit_map_wr | input | 1 | Write one bit of the EOI exit bitmap |
| exit_map_vec | input | 8 | Bit index for the exit bitmap write |
| exit_map_set | input | 1 | Value written into the exit bitmap |
| win_exit_ctl | input | 1 | Interrupt-window exiting control; 1 blocks recognition |
| dlv_valid | output | 1 | A vector is offered |
| dlv_ready | input | 1 | Consumer accepts the offered vector |
| dlv_vec | output | 8 | Offered vector |
| eoi_exit_valid | output | 1 | One-cycle exit event caused by an EOI |
| eoi_exit_vec | output | 8 | Vector whose EOI caused the exit |
| req_vec | output | 8 | Requesting-vector register |
| svc_vec | output | 8 | Servicing-vector register |
| cur_prio | output | 8 | Current priority register |

## Verification
The checker runs on every cycle. It confirms that a newly offered vector has a strictly higher class than the priority in force when it was recognized, with the window control clear. It confirms that an offer holds steady under back-pressure, and that an accepted vector becomes the servicing vector and sets the priority class. It also confirms that an EOI never raises the servicing vector, that a priority write never leaves a class below the one written, and that low vectors never reach req_vec or dlv_vec. Some behaviour can only be shown by the directed scenarios: that nothing is offered without an evaluation event, that each of the five event sources triggers recognition, the exact order in which stacked requests and nested in-service vectors drain, and whether an exit event is raised or suppressed according to the exit bitmap.

// File: rtl/vintr_pkg.sv
package vintr_pkg;
   // Bit position where the priority class of a vector begins
   localparam int CLS_LSB = 4;

   // Implementation variant of the highest-set-bit search
   typedef enum logic [0:0] {
      ENC_LINEAR  = 1'b0,
      ENC_GROUPED = 1'b1
   } enc_style_e;
endpackage

// File: rtl/vintr_prio_enc.sv
module vintr_prio_enc
   import vintr_pkg::*;
#(
   parameter int         N     = 256,
   parameter int         W     = $clog2(N),
   parameter int         LOW   = 16,
   parameter enc_style_e STYLE = ENC_GROUPED
) (
   input  logic [N-1:0] vec_i,
   output logic [W-1:0] idx_o,
   output logic         hit_o
);
   localparam int G  = 1 << CLS_LSB;
   localparam int NG = N / G;
   localparam int GW = (NG > 1) ? $clog2(NG) : 1;

   // Bits below LOW never take part in the search
   logic [N-1:0] masked;
   for (genvar i = 0; i < N; i++) begin : g_mask
      if (i >= LOW) begin : g_keep
         assign masked[i] = vec_i[i];
      end else begin : g_drop
         assign masked[i] = 1'b0;
      end
   end

   if (STYLE == ENC_LINEAR) begin : g_linear
      always_comb begin
         idx_o = '0;
         hit_o = 1'b0;
         for (int i = 0; i < N; i++) begin
            if (masked[i]) begin
               idx_o = W'(i);
               hit_o = 1'b1;
            end
         end
      end
   end else begin : g_grouped
      logic [NG-1:0]      grp_any;
      logic [GW-1:0]      grp_sel;
      logic [G-1:0]       grp_bits;
      logic [CLS_LSB-1:0] low_sel;

      for (genvar g = 0; g < NG; g++) begin : g_or
         assign grp_any[g] = |masked[g*G +: G];
      end

      always_comb begin
         grp_sel = '0;
         for (int g = 0; g < NG; g++) begin
            if (grp_any[g]) grp_sel = GW'(g);
         end
      end

      assign grp_bits = masked[grp_sel*G +: G];

      always_comb begin
         low_sel = '0;
         for (int j = 0; j < G; j++) begin
            if (grp_bits[j]) low_sel = CLS_LSB'(j);
         end
      end

      assign hit_o = |grp_any;
      assign idx_o = hit_o ? W'({grp_sel, low_sel}) : '0;
   end
endmodule

// File: rtl/vintr_eval.sv
module vintr_eval
   import vintr_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic             win_i,
   input  logic [VEC_W-1:0] rvec_i,
   input  logic [VEC_W-1:0] prio_i,
   input  logic             ready_i,
   output logic             valid_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             accept_o
);
   logic eval_q;
   logic recog;

   // A pending vector is recognized only in the cycle after an evaluation event
   assign recog = eval_q && !win_i && !valid_o &&
                  (rvec_i[VEC_W-1:CLS_LSB] > prio_i[VEC_W-1:CLS_LSB]);

   assign accept_o = valid_o && ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eval_q  <= 1'b0;
         valid_o <= 1'b0;
         vec_o   <= '0;
      end else begin
         // An event seen while an offer is outstanding is kept for later
         eval_q <= trig_i || (eval_q && valid_o);
         if (recog) begin
            valid_o <= 1'b1;
            vec_o   <= rvec_i;
         end else if (accept_o) begin
            valid_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/vintr_exit_map.sv
module vintr_exit_map #(
   parameter int NUM_VEC = 256,
   parameter int VEC_W   = $clog2(NUM_VEC),
   parameter int LOW     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [VEC_W-1:0] wr_vec_i,
   input  logic             wr_set_i,
   input  logic             eoi_i,
   input  logic [VEC_W-1:0] svc_i,
   output logic             exit_valid_o,
   output logic [VEC_W-1:0] exit_vec_o
);
   logic [NUM_VEC-1:0] map_q;
   logic               hit;

   assign hit = eoi_i && (svc_i >= VEC_W'(LOW)) && map_q[svc_i];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         map_q        <= '0;
         exit_valid_o <= 1'b0;
         exit_vec_o   <= '0;
      end else begin
         if (wr_i) map_q[wr_vec_i] <= wr_set_i;
         exit_valid_o <= hit;
         if (hit) exit_vec_o <= svc_i;
      end
   end
endmodule

// File: rtl/vintr_ctrl.sv
module vintr_ctrl
   import vintr_pkg::*;
#(
   parameter int         NUM_VEC = 256,
   parameter int         MIN_VEC = 16,
   parameter enc_style_e STYLE   = ENC_GROUPED,
   localparam int        VEC_W   = $clog2(NUM_VEC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             post_valid,
   input  logic [VEC_W-1:0] post_vec,
   input  logic             self_ipi_valid,
   input  logic [VEC_W-1:0] self_ipi_vec,
   input  logic             vm_entry,
   input  logic             prio_wr,
   input  logic [VEC_W-1:0] prio_val,
   input  logic             eoi_wr,
   input  logic             exit_map_wr,
   input  logic [VEC_W-1:0] exit_map_vec,
   input  logic             exit_map_set,
   input  logic             win_exit_ctl,
   output logic             dlv_valid,
   input  logic             dlv_ready,
   output logic [VEC_W-1:0] dlv_vec,
   output logic             eoi_exit_valid,
   output logic [VEC_W-1:0] eoi_exit_vec,
   output logic [VEC_W-1:0] req_vec,
   output logic [VEC_W-1:0] svc_vec,
   output logic [VEC_W-1:0] cur_prio
);
   if (NUM_VEC < 32 || (1 << VEC_W) != NUM_VEC) begin : g_bad_num
      $error("vintr_ctrl: NUM_VEC must be a power of two of at least 32");
   end
   if (MIN_VEC < 0 || MIN_VEC >= NUM_VEC) begin : g_bad_min
      $error("vintr_ctrl: MIN_VEC out of range");
   end

   logic [NUM_VEC-1:0] req_q, req_d;
   logic [NUM_VEC-1:0] isr_q, isr_d, isr_eoi;
   logic [VEC_W-1:0]   tprio_q, tprio_d;
   logic [VEC_W-1:0]   svc_d, prio_d, rvec_d;
   logic [VEC_W-1:0]   req_idx, isr_idx;
   logic               req_hit, isr_hit;
   logic               accept, trig;

   // Priority in force: task priority unless the servicing class is above it
   function automatic logic [VEC_W-1:0] prio_of(input logic [VEC_W-1:0] tp,
                                                input logic [VEC_W-1:0] sv);
      logic [VEC_W-1:0] cls;
      cls = {sv[VEC_W-1:CLS_LSB], {CLS_LSB{1'b0}}};
      return (tp[VEC_W-1:CLS_LSB] >= sv[VEC_W-1:CLS_LSB]) ? tp : cls;
   endfunction

   assign trig = post_valid || self_ipi_valid || vm_entry || prio_wr || eoi_wr;

   always_comb begin
      isr_eoi = isr_q;
      if (eoi_wr) isr_eoi[svc_vec] = 1'b0;
   end

   vintr_prio_enc #(
      .N(NUM_VEC), .W(VEC_W), .LOW(MIN_VEC), .STYLE(STYLE)
   ) i_isr_enc (
      .vec_i(isr_eoi), .idx_o(isr_idx), .hit_o(isr_hit)
   );

   // State update in order: EOI, priority write, accepted offer, new requests
   always_comb begin
      req_d   = req_q;
      isr_d   = isr_q;
      svc_d   = svc_vec;
      prio_d  = cur_prio;
      tprio_d = tprio_q;
      if (eoi_wr) begin
         isr_d = isr_eoi;
         svc_d = isr_hit ? isr_idx : '0;
      end
      if (prio_wr) tprio_d = prio_val;
      if (eoi_wr || prio_wr) prio_d = prio_of(tprio_d, svc_d);
      if (accept) begin
         isr_d[dlv_vec] = 1'b1;
         req_d[dlv_vec] = 1'b0;
         svc_d          = dlv_vec;
         prio_d         = {dlv_vec[VEC_W-1:CLS_LSB], {CLS_LSB{1'b0}}};
      end
      if (post_valid)     req_d[post_vec]     = 1'b1;
      if (self_ipi_valid) req_d[self_ipi_vec] = 1'b1;
   end

   vintr_prio_enc #(
      .N(NUM_VEC), .W(VEC_W), .LOW(MIN_VEC), .STYLE(STYLE)
   ) i_req_enc (
      .vec_i(req_d), .idx_o(req_idx), .hit_o(req_hit)
   );

   assign rvec_d = req_hit ? req_idx : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q    <= '0;
         isr_q    <= '0;
         tprio_q  <= '0;
         req_vec  <= '0;
         svc_vec  <= '0;
         cur_prio <= '0;
      end else begin
         req_q    <= req_d;
         isr_q    <= isr_d;
         tprio_q  <= tprio_d;
         req_vec  <= rvec_d;
         svc_vec  <= svc_d;
         cur_prio <= prio_d;
      end
   end

   vintr_eval #(.VEC_W(VEC_W)) i_eval (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .win_i(win_exit_ctl),
      .rvec_i(req_vec), .prio_i(cur_prio), .ready_i(dlv_ready),
      .valid_o(dlv_valid), .vec_o(dlv_vec), .accept_o(accept)
   );

   vintr_exit_map #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .LOW(MIN_VEC)) i_exit (
      .clk(clk), .rst_n(rst_n), .wr_i(exit_map_wr), .wr_vec_i(exit_map_vec),
      .wr_set_i(exit_map_set), .eoi_i(eoi_wr), .svc_i(svc_vec),
      .exit_valid_o(eoi_exit_valid), .exit_vec_o(eoi_exit_vec)
   );
endmodule

// File: rtl/vintr_ctrl_chk.sv
module vintr_ctrl_chk #(
   parameter int VEC_W   = 8,
   parameter int MIN_VEC = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             eoi_wr,
   input logic             prio_wr,
   input logic [VEC_W-1:0] prio_val,
   input logic             win_exit_ctl,
   input logic             dlv_valid,
   input logic             dlv_ready,
   input logic [VEC_W-1:0] dlv_vec,
   input logic             eoi_exit_valid,
   input logic [VEC_W-1:0] req_vec,
   input logic [VEC_W-1:0] svc_vec,
   input logic [VEC_W-1:0] cur_prio
);
   localparam int CL = vintr_pkg::CLS_LSB;

   assert_offer_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dlv_valid) |-> (dlv_vec[VEC_W-1:CL] > $past(cur_prio[VEC_W-1:CL]))
                           && !$past(win_exit_ctl));

   assert_accept_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid && dlv_ready |=> (svc_vec == $past(dlv_vec)) &&
         (cur_prio[VEC_W-1:CL] == $past(dlv_vec[VEC_W-1:CL])) &&
         (cur_prio[CL-1:0] == '0));

   assert_req_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vec == '0) || (req_vec >= VEC_W'(MIN_VEC)));

   assert_eoi_lowers_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_wr && !prio_wr && !(dlv_valid && dlv_ready) |=>
         (svc_vec == '0) || (svc_vec < $past(svc_vec)));

   assert_exit_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_exit_valid |-> $past(eoi_wr));

   assert_prio_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
      prio_wr && !eoi_wr && !(dlv_valid && dlv_ready) |=>
         cur_prio[VEC_W-1:CL] >= $past(prio_val[VEC_W-1:CL]));

   assert_no_low_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> dlv_vec >= VEC_W'(MIN_VEC));

   assert_offer_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_vec));
endmodule

bind vintr_ctrl vintr_ctrl_chk #(.VEC_W(VEC_W), .MIN_VEC(MIN_VEC)) i_vintr_chk (
   .clk(clk), .rst_n(rst_n), .eoi_wr(eoi_wr), .prio_wr(prio_wr),
   .prio_val(prio_val), .win_exit_ctl(win_exit_ctl), .dlv_valid(dlv_valid),
   .dlv_ready(dlv_ready), .dlv_vec(dlv_vec), .eoi_exit_valid(eoi_exit_valid),
   .req_vec(req_vec), .svc_vec(svc_vec), .cur_prio(cur_prio)
);

// File: tb/test_vintr_ctrl.sv
module test_vintr_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       post_valid = 1'b0;
   logic [7:0] post_vec = '0;
   logic       self_ipi_valid = 1'b0;
   logic [7:0] self_ipi_vec = '0;
   logic       vm_entry = 1'b0;
   logic       prio_wr = 1'b0;
   logic [7:0] prio_val = '0;
   logic       eoi_wr = 1'b0;
   logic       exit_map_wr = 1'b0;
   logic [7:0] exit_map_vec = '0;
   logic       exit_map_set = 1'b0;
   logic       win_exit_ctl = 1'b0;
   logic       dlv_ready = 1'b0;
   logic       dlv_valid, eoi_exit_valid;
   logic [7:0] dlv_vec, eoi_exit_vec, req_vec, svc_vec, cur_prio;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #4 clk = ~clk;

   vintr_ctrl i_vintr_ctrl (
      .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_vec(post_vec),
      .self_ipi_valid(self_ipi_valid), .self_ipi_vec(self_ipi_vec),
      .vm_entry(vm_entry), .prio_wr(prio_wr), .prio_val(prio_val),
      .eoi_wr(eoi_wr), .exit_map_wr(exit_map_wr), .exit_map_vec(exit_map_vec),
      .exit_map_set(exit_map_set), .win_exit_ctl(win_exit_ctl),
      .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_vec(dlv_vec),
      .eoi_exit_valid(eoi_exit_valid), .eoi_exit_vec(eoi_exit_vec),
      .req_vec(req_vec), .svc_vec(svc_vec), .cur_prio(cur_prio)
   );

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic post(input logic [7:0] v);
      post_valid = 1'b1; post_vec = v; tick(); post_valid = 1'b0;
   endtask
   task automatic self_int(input logic [7:0] v);
      self_ipi_valid = 1'b1; self_ipi_vec = v; tick(); self_ipi_valid = 1'b0;
   endtask
   task automatic eoi();
      eoi_wr = 1'b1; tick(); eoi_wr = 1'b0;
   endtask
   task automatic set_prio(input logic [7:0] v);
      prio_wr = 1'b1; prio_val = v; tick(); prio_wr = 1'b0;
   endtask
   task automatic entry();
      vm_entry = 1'b1; tick(); vm_entry = 1'b0;
   endtask
   task automatic take();
      dlv_ready = 1'b1; tick(); dlv_ready = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 dlv_valid", dlv_valid, 0);
      chk("R1 eoi_exit_valid", eoi_exit_valid, 0);
      chk("R1 req_vec", req_vec, 0);
      chk("R1 svc_vec", svc_vec, 0);
      chk("R1 cur_prio", cur_prio, 0);
   endtask

   task automatic t_low_vec();
      post(8'h05); tick(2);
      chk("R10 low post req_vec", req_vec, 0);
      chk("R10 low post dlv_valid", dlv_valid, 0);
   endtask

   task automatic t_deliver();
      post(8'h45);
      chk("R4 req_vec after post", req_vec, 8'h45);
      chk("R2 no offer before eval", dlv_valid, 0);
      tick();
      chk("R6 post triggers offer", dlv_valid, 1);
      chk("R2 offered vec", dlv_vec, 8'h45);
      tick();
      chk("R11 held valid", dlv_valid, 1);
      chk("R11 held vec", dlv_vec, 8'h45);
      take();
      chk("R3 valid drops", dlv_valid, 0);
      chk("R3 svc_vec", svc_vec, 8'h45);
      chk("R3 cur_prio", cur_prio, 8'h40);
      chk("R4 req_vec empty", req_vec, 0);
   endtask

   task automatic t_class();
      post(8'h4A); tick();
      chk("R2 equal class not offered", dlv_valid, 0);
      chk("R4 req_vec", req_vec, 8'h4A);
      post(8'h61);
      chk("R4 req_vec higher", req_vec, 8'h61);
      tick();
      chk("R2 higher class offered", dlv_vec, 8'h61);
      take();
      chk("R3 svc_vec nested", svc_vec, 8'h61);
      chk("R3 cur_prio nested", cur_prio, 8'h60);
      chk("R4 req_vec reload", req_vec, 8'h4A);
   endtask

   task automatic t_eoi();
      eoi();
      chk("R7 svc_vec to next", svc_vec, 8'h45);
      chk("R7 cur_prio", cur_prio, 8'h40);
      tick();
      chk("R2 after eoi equal class", dlv_valid, 0);
      eoi();
      chk("R7 svc_vec empty", svc_vec, 0);
      chk("R7 cur_prio zero", cur_prio, 0);
      tick();
      chk("R6 eoi triggers offer", dlv_valid, 1);
      chk("R6 eoi offer vec", dlv_vec, 8'h4A);
      take();
      chk("R3 svc_vec", svc_vec, 8'h4A);
   endtask

   task automatic t_prio();
      set_prio(8'h30);
      chk("R9 lower task prio", cur_prio, 8'h40);
      set_prio(8'h72);
      chk("R9 higher task prio", cur_prio, 8'h72);
      eoi();
      chk("R7 prio after eoi", cur_prio, 8'h72);
      chk("R7 svc empty", svc_vec, 0);
      post(8'h75); tick();
      chk("R2 blocked by task prio", dlv_valid, 0);
      set_prio(8'h20);
      chk("R9 lowered", cur_prio, 8'h20);
      tick();
      chk("R6 prio write triggers", dlv_valid, 1);
      chk("R6 prio write vec", dlv_vec, 8'h75);
      take();
      chk("R3 cur_prio", cur_prio, 8'h70);
      eoi();
      chk("R7 prio back to task", cur_prio, 8'h20);
   endtask

   task automatic t_window();
      win_exit_ctl = 1'b1;
      self_int(8'h90);
      chk("R4 req_vec self", req_vec, 8'h90);
      tick(2);
      chk("R2 window blocks", dlv_valid, 0);
      win_exit_ctl = 1'b0;
      tick(3);
      chk("R5 no offer without event", dlv_valid, 0);
      entry(); tick();
      chk("R6 entry triggers", dlv_valid, 1);
      chk("R6 entry vec", dlv_vec, 8'h90);
      take();
      chk("R3 svc_vec", svc_vec, 8'h90);
      tick(2);
      chk("R5 no second offer", dlv_valid, 0);
      eoi();
      chk("R7 svc empty", svc_vec, 0);
   endtask

   task automatic t_exit();
      exit_map_wr = 1'b1; exit_map_vec = 8'hA3; exit_map_set = 1'b1;
      tick(); exit_map_wr = 1'b0;
      post(8'hA3); tick(); take();
      chk("R3 svc_vec", svc_vec, 8'hA3);
      eoi();
      chk("R8 exit valid", eoi_exit_valid, 1);
      chk("R8 exit vec", eoi_exit_vec, 8'hA3);
      tick();
      chk("R8 exit one cycle", eoi_exit_valid, 0);
      post(8'hB1); tick(); take();
      eoi();
      chk("R8 unmapped no exit", eoi_exit_valid, 0);
      chk("R7 svc empty", svc_vec, 0);
   endtask

   task automatic t_order();
      win_exit_ctl = 1'b1;
      post(8'h30); post(8'hE0); post(8'h81);
      chk("R4 highest pending", req_vec, 8'hE0);
      win_exit_ctl = 1'b0;
      entry(); tick();
      chk("R2 first E0", dlv_vec, 8'hE0);
      take();
      chk("R4 reload 81", req_vec, 8'h81);
      eoi(); tick();
      chk("R2 second 81", dlv_vec, 8'h81);
      take();
      chk("R4 reload 30", req_vec, 8'h30);
      eoi(); tick();
      chk("R2 third 30", dlv_vec, 8'h30);
      take();
      chk("R10 low bit still ignored", req_vec, 0);
      eoi();
      chk("R7 final svc", svc_vec, 0);
   endtask

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_low_vec();
      t_deliver();
      t_class();
      t_eoi();
      t_prio();
      t_window();
      t_exit();
      t_order();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule